// File: doc/BRIEF.md
# NOR flash command sequence decoder

This block sits behind the pins of a parallel NOR flash and turns host write cycles into operation requests. It samples chip-enable, write-enable and output-enable with the core clock and forms one write cycle from each period in which both enables are low while output-enable is high. It matches each cycle's address and data against a branching unlock grammar of one, three, four or six cycles. When a command completes, it raises a one-clock request that carries an operation code and the address and data of the deciding cycle.

It also holds three mode flags that the read path and the embedded controllers consult: identification mode, query mode, and a sticky single-pulse program mode. In single-pulse program mode every later write is a program request. The array, the program and erase timers and the status bits are not part of this block. The embedded controller drives `prog_busy` to tell the decoder that a program is running.

Top module: `nor_cmd_decoder`

## Requirements
- R1: A write cycle is a period with `ce_n` and `we_n` both low and `oe_n` high. The address is taken at the first clock that sees both enables low. The data is taken at the first clock after that which sees the cycle over. Any request this cycle produces is shown on `op_valid` exactly one clock later. No cycle is formed while `oe_n` is low.
- R2: Matching uses only address bits 10..0, so A11 and every bit above it are ignored and 2AA stands for AAA. Data bits 15..8 are ignored. The unlock pair is AA at 555 followed by 55 at 2AA.
- R3: Unlock followed by A0 at 555 makes the next cycle issue PROGRAM (op_kind 1), carrying that cycle's full address and data.
- R4: Unlock, 80 at 555, then a second unlock, leads to a sixth cycle that decides the command. 10 at 555 issues CHIP_ERASE (2). 30 issues SECTOR_ERASE (3). 60 issues SECTOR_LOCK (4). A0 issues SPM_ENTER (13). Each request carries the sixth cycle's address and data.
- R5: From idle, a single cycle issues a command: B0 at any address gives SUSPEND (5), 30 gives RESUME (6), F0 gives ID_EXIT (8), and 98 with address bits 7..0 equal to 55 gives CFI_ENTER (9).
- R6: Unlock followed by 90 at 555 issues ID_ENTER (7) and sets `id_mode`. Unlock followed by F0 at 555, like the single F0, issues ID_EXIT (8) and clears both `id_mode` and `cfi_mode`.
- R7: The query command is accepted whether or not `id_mode` is set. It sets `cfi_mode` and leaves `id_mode` unchanged.
- R8: Unlock followed by C0 at 555 makes the next cycle a protection request. At address 080 with data bit 1 equal to 0 it is PROT_LOCK (11). Otherwise it is PROT_PROGRAM (10).
- R9: Unlock followed by D0 at 555 makes the next cycle issue CFG_WRITE (12) if its low data byte is 00 or 01. Any other value issues nothing.
- R10: After SPM_ENTER, `spm_mode` stays set until reset. While it is set, every write cycle, including any command code, issues PROGRAM (1) with its own address and data.
- R11: A write cycle that completes while `prog_busy` is high issues nothing and leaves the partial sequence where it was.
- R12: A cycle that does not fit the expected next step returns the decoder to idle and issues nothing, even if that cycle alone would be a single-cycle command.
- R13: `rst_n` low at a clock edge clears `op_valid`, the partial sequence, `id_mode`, `cfi_mode` and `spm_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low, already synchronised |
| we_n | input | 1 | Write enable, active low, already synchronised |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| addr | input | ADDR_W | Word address pins |
| data | input | DATA_W | Data pins, input side |
| prog_busy | input | 1 | High while an embedded program runs |
| op_valid | output | 1 | One-clock operation request |
| op_kind | output | 4 | Operation code, valid with op_valid |
| op_addr | output | ADDR_W | Address of the deciding cycle |
| op_data | output | DATA_W | Data of the deciding cycle |
| id_mode | output | 1 | Identification mode flag |
| cfi_mode | output | 1 | Query mode flag |
| spm_mode | output | 1 | Single-pulse program mode flag |

## Verification
The bench targets the decision points of the grammar. A11 is set in the unlock address, so a decoder that compares twelve bits would drop that program. The protection request is sent at 080 with bit 1 both clear and set, so swapping lock and program shows up. B0 is sent as the breaking second cycle, so a decoder that reparses a breaking cycle would issue a stray suspend. A write is made while busy in the middle of a sequence, so a decoder that resets on ignored cycles would lose the program that follows. It also drives a write in which chip-enable falls first and the address and data change while the cycle is active, which exposes latching on the wrong edge. Finally, command codes are sent in single-pulse mode and after reset, which catches a mode that is not sticky or that outlives reset.

// File: rtl/ncd_pkg.sv
// Shared codes for the NOR command decoder.
// Assumes word addressing with matching confined to address bits 10..0.
package ncd_pkg;

    typedef enum logic [3:0] {
        OP_NONE         = 4'd0,
        OP_PROGRAM      = 4'd1,
        OP_CHIP_ERASE   = 4'd2,
        OP_SECTOR_ERASE = 4'd3,
        OP_SECTOR_LOCK  = 4'd4,
        OP_SUSPEND      = 4'd5,
        OP_RESUME       = 4'd6,
        OP_ID_ENTER     = 4'd7,
        OP_ID_EXIT      = 4'd8,
        OP_CFI_ENTER    = 4'd9,
        OP_PROT_PROGRAM = 4'd10,
        OP_PROT_LOCK    = 4'd11,
        OP_CFG_WRITE    = 4'd12,
        OP_SPM_ENTER    = 4'd13
    } op_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PGM,
        ST_PROT,
        ST_CFG,
        ST_EXT3,
        ST_EXT4,
        ST_EXT5
    } seq_state_e;

    localparam int unsigned CMP_W = 11;

    localparam logic [CMP_W-1:0] ADR_KEY_A     = 11'h555;
    localparam logic [CMP_W-1:0] ADR_KEY_B     = 11'h2AA;
    localparam logic [CMP_W-1:0] ADR_PROT_LOCK = 11'h080;
    localparam logic [7:0]       ADR_QUERY_LO  = 8'h55;

    localparam logic [7:0] CMD_KEY_A    = 8'hAA;
    localparam logic [7:0] CMD_KEY_B    = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_EXTEND   = 8'h80;
    localparam logic [7:0] CMD_ID_ENTER = 8'h90;
    localparam logic [7:0] CMD_ID_EXIT  = 8'hF0;
    localparam logic [7:0] CMD_PROT     = 8'hC0;
    localparam logic [7:0] CMD_CFG      = 8'hD0;
    localparam logic [7:0] CMD_CHIP     = 8'h10;
    localparam logic [7:0] CMD_SECTOR   = 8'h30;
    localparam logic [7:0] CMD_LOCK     = 8'h60;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] CMD_RESUME   = 8'h30;
    localparam logic [7:0] CMD_QUERY    = 8'h98;

endpackage

// File: rtl/ncd_bus_capture.sv
// Forms write cycles from sampled flash control pins.
// Assumes ce_n, we_n, oe_n, addr and data are already synchronous to clk.
// The address is taken when the write becomes active (the later falling enable).
// The data is taken when it ends (the first rising enable), and cyc_stb pulses once.
module ncd_bus_capture #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              cyc_stb,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_data
);

    logic wr_act;
    logic wr_act_q;

    // A write needs both enables low with the outputs disabled.
    always_comb begin
        wr_act = !ce_n && !we_n && oe_n;
    end

    // Track the active window and latch address at its start, data at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            cyc_stb  <= 1'b0;
            cyc_addr <= '0;
            cyc_data <= '0;
        end else begin
            wr_act_q <= wr_act;
            cyc_stb  <= wr_act_q && !wr_act;
            if (wr_act && !wr_act_q) begin
                cyc_addr <= addr;
            end
            if (wr_act_q && !wr_act) begin
                cyc_data <= data;
            end
        end
    end

endmodule

// File: rtl/ncd_seq_decoder.sv
// Unlock grammar walker: consumes one write cycle per cyc_stb and issues
// a registered one-clock request when a command completes.
// Assumes cyc_addr/cyc_data are stable while cyc_stb is high.
// Cycles arriving with busy high are dropped without moving the state.
module ncd_seq_decoder
    import ncd_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_data,
    input  logic              busy,
    input  logic              spm_mode,
    output logic              op_valid,
    output logic [3:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);

    seq_state_e       state_q;
    seq_state_e       state_d;
    op_kind_e         kind_d;
    op_kind_e         kind_q;
    logic [CMP_W-1:0] a_lo;
    logic [7:0]       cmd;
    logic             at_key_a;
    logic             at_key_b;

    // Reduced views used by every comparison.
    always_comb begin
        a_lo     = cyc_addr[CMP_W-1:0];
        cmd      = cyc_data[7:0];
        at_key_a = (a_lo == ADR_KEY_A);
        at_key_b = (a_lo == ADR_KEY_B);
    end

    // Next state and request for the current write cycle.
    always_comb begin
        state_d = state_q;
        kind_d  = OP_NONE;
        if (cyc_stb && !busy) begin
            state_d = ST_IDLE;
            if (spm_mode) begin
                kind_d = OP_PROGRAM;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (cmd == CMD_KEY_A && at_key_a) begin
                            state_d = ST_UNL1;
                        end else if (cmd == CMD_SUSPEND) begin
                            kind_d = OP_SUSPEND;
                        end else if (cmd == CMD_RESUME) begin
                            kind_d = OP_RESUME;
                        end else if (cmd == CMD_ID_EXIT) begin
                            kind_d = OP_ID_EXIT;
                        end else if (cmd == CMD_QUERY && cyc_addr[7:0] == ADR_QUERY_LO) begin
                            kind_d = OP_CFI_ENTER;
                        end
                    end
                    ST_UNL1: begin
                        if (cmd == CMD_KEY_B && at_key_b) begin
                            state_d = ST_UNL2;
                        end
                    end
                    ST_UNL2: begin
                        if (at_key_a) begin
                            case (cmd)
                                CMD_PROGRAM:  state_d = ST_PGM;
                                CMD_EXTEND:   state_d = ST_EXT3;
                                CMD_PROT:     state_d = ST_PROT;
                                CMD_CFG:      state_d = ST_CFG;
                                CMD_ID_ENTER: kind_d  = OP_ID_ENTER;
                                CMD_ID_EXIT:  kind_d  = OP_ID_EXIT;
                                default:      state_d = ST_IDLE;
                            endcase
                        end
                    end
                    ST_PGM: begin
                        kind_d = OP_PROGRAM;
                    end
                    ST_PROT: begin
                        if (a_lo == ADR_PROT_LOCK && !cyc_data[1]) begin
                            kind_d = OP_PROT_LOCK;
                        end else begin
                            kind_d = OP_PROT_PROGRAM;
                        end
                    end
                    ST_CFG: begin
                        if (cmd == 8'h00 || cmd == 8'h01) begin
                            kind_d = OP_CFG_WRITE;
                        end
                    end
                    ST_EXT3: begin
                        if (cmd == CMD_KEY_A && at_key_a) begin
                            state_d = ST_EXT4;
                        end
                    end
                    ST_EXT4: begin
                        if (cmd == CMD_KEY_B && at_key_b) begin
                            state_d = ST_EXT5;
                        end
                    end
                    ST_EXT5: begin
                        case (cmd)
                            CMD_CHIP:    kind_d = at_key_a ? OP_CHIP_ERASE : OP_NONE;
                            CMD_SECTOR:  kind_d = OP_SECTOR_ERASE;
                            CMD_LOCK:    kind_d = OP_SECTOR_LOCK;
                            CMD_PROGRAM: kind_d = OP_SPM_ENTER;
                            default:     kind_d = OP_NONE;
                        endcase
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    // Register the sequence position and the outgoing request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= OP_NONE;
            op_valid <= 1'b0;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            state_q  <= state_d;
            kind_q   <= kind_d;
            op_valid <= (kind_d != OP_NONE);
            if (kind_d != OP_NONE) begin
                op_addr <= cyc_addr;
                op_data <= cyc_data;
            end
        end
    end

    // Expose the code as a plain vector.
    always_comb begin
        op_kind = kind_q;
    end

endmodule

// File: rtl/ncd_mode_track.sv
// Holds the identification, query and single-pulse mode flags.
// Assumes requests arrive as one-clock pulses; flags change the clock after.
module ncd_mode_track
    import ncd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [3:0] op_kind,
    output logic       id_mode,
    output logic       cfi_mode,
    output logic       spm_mode
);

    // Update flags from completed requests; reset clears all of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_mode  <= 1'b0;
            cfi_mode <= 1'b0;
            spm_mode <= 1'b0;
        end else if (op_valid) begin
            case (op_kind)
                OP_ID_ENTER:  id_mode  <= 1'b1;
                OP_CFI_ENTER: cfi_mode <= 1'b1;
                OP_SPM_ENTER: spm_mode <= 1'b1;
                OP_ID_EXIT: begin
                    id_mode  <= 1'b0;
                    cfi_mode <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nor_cmd_decoder.sv
// Top of the NOR flash command decoder: pin capture, grammar walker, mode flags.
// Assumes pins are synchronised to clk and each enable phase spans at least one clock.
module nor_cmd_decoder #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              prog_busy,
    output logic              op_valid,
    output logic [3:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode,
    output logic              cfi_mode,
    output logic              spm_mode
);

    logic              cap_stb;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    ncd_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .data     (data),
        .cyc_stb  (cap_stb),
        .cyc_addr (cap_addr),
        .cyc_data (cap_data)
    );

    ncd_seq_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_stb  (cap_stb),
        .cyc_addr (cap_addr),
        .cyc_data (cap_data),
        .busy     (prog_busy),
        .spm_mode (spm_mode),
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .op_addr  (op_addr),
        .op_data  (op_data)
    );

    ncd_mode_track u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .id_mode  (id_mode),
        .cfi_mode (cfi_mode),
        .spm_mode (spm_mode)
    );

endmodule

// File: rtl/ncd_checker.sv
// Protocol checks for nor_cmd_decoder, attached by bind.
// Assumes rst_n is held low from time zero through at least one clock edge.
module ncd_checker
    import ncd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       stb,
    input logic       busy,
    input logic       op_valid,
    input logic [3:0] op_kind,
    input logic       id_mode,
    input logic       cfi_mode,
    input logic       spm_mode
);

    // R1: a request only ever follows a completed write cycle.
    a_r1_req_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(stb));

    // R11: a cycle completing under busy issues nothing.
    a_r11_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && busy) |=> !op_valid);

    // R10: in single-pulse mode every accepted cycle is a program request.
    a_r10_spm_programs: assert property (@(posedge clk) disable iff (!rst_n)
        (spm_mode && stb && !busy) |=> (op_valid && op_kind == OP_PROGRAM));

    // R10: single-pulse mode never drops without reset.
    a_r10_spm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        spm_mode |=> spm_mode);

    // R6: an exit request clears both identification and query flags.
    a_r6_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == OP_ID_EXIT) |=> (!id_mode && !cfi_mode));

    // R13: reset leaves no request and no mode set.
    a_r13_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!op_valid && !id_mode && !cfi_mode && !spm_mode));

endmodule

bind nor_cmd_decoder ncd_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (cap_stb),
    .busy     (prog_busy),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .id_mode  (id_mode),
    .cfi_mode (cfi_mode),
    .spm_mode (spm_mode)
);

// File: tb/nor_cmd_decoder_tb.sv
// Scoreboard bench: write tasks push expected requests, a monitor pops and compares.
module nor_cmd_decoder_tb;

    localparam int unsigned AW = 19;
    localparam int unsigned DW = 16;
    localparam int unsigned IW = 4 + AW + DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          prog_busy = 1'b0;
    logic          op_valid;
    logic [3:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic          id_mode;
    logic          cfi_mode;
    logic          spm_mode;

    int errors = 0;
    int checks = 0;
    logic [IW-1:0] exp_q[$];
    string         tag_q[$];

    always #10 clk = ~clk;

    nor_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .data(data), .prog_busy(prog_busy),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .id_mode(id_mode), .cfi_mode(cfi_mode), .spm_mode(spm_mode)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_op(input logic [3:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        exp_q.push_back({k, a, d});
        tag_q.push_back(tag);
    endtask

    // Plain write: both enables fall together, rise together.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic unlock();
        wr(19'h00555, 16'h00AA);
        wr(19'h002AA, 16'h0055);
    endtask

    task automatic ext_prefix();
        unlock();
        wr(19'h00555, 16'h0080);
        unlock();
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic chk_modes(input bit id_e, input bit cfi_e, input bit spm_e, input string tag);
        chk({id_mode, cfi_mode, spm_mode} == {id_e, cfi_e, spm_e}, tag,
            64'({id_mode, cfi_mode, spm_mode}), 64'({id_e, cfi_e, spm_e}));
    endtask

    // Monitor: every request must match the head of the expectation queue.
    always @(negedge clk) begin
        if (rst_n && op_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected request", 64'({op_kind, op_addr, op_data}), 64'd0);
            end else begin
                logic [IW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({op_kind, op_addr, op_data} == e, t, 64'({op_kind, op_addr, op_data}), 64'(e));
            end
        end
    end

    // Watchdog: an overlong run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1 watchdog expired", 64'd0, 64'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(op_valid == 1'b0, "R13 reset op_valid", 64'(op_valid), 64'd0);
        chk_modes(0, 0, 0, "R13 reset modes");
        rst_n = 1'b1;
        @(negedge clk);

        // R3 program
        unlock(); wr(19'h00555, 16'h00A0);
        expect_op(4'd1, 19'h12345, 16'hBEEF, "R3 program");
        wr(19'h12345, 16'hBEEF);

        // R2 upper address bits, A11 and high data byte ignored
        wr(19'h7F555, 16'h33AA); wr(19'h00AAA, 16'h5555); wr(19'h40D55, 16'h12A0);
        expect_op(4'd1, 19'h00042, 16'h0000, "R2 masked unlock");
        wr(19'h00042, 16'h0000);

        // R4 sixth-cycle commands
        ext_prefix();
        expect_op(4'd2, 19'h00555, 16'h0010, "R4 chip erase");
        wr(19'h00555, 16'h0010);
        ext_prefix();
        expect_op(4'd3, 19'h48000, 16'h0030, "R4 sector erase");
        wr(19'h48000, 16'h0030);
        ext_prefix();
        expect_op(4'd4, 19'h03000, 16'h0060, "R4 sector lock");
        wr(19'h03000, 16'h0060);

        // R5 single-cycle commands
        expect_op(4'd5, 19'h01234, 16'h00B0, "R5 suspend");
        wr(19'h01234, 16'h00B0);
        expect_op(4'd6, 19'h00777, 16'h0030, "R5 resume");
        wr(19'h00777, 16'h0030);
        expect_op(4'd8, 19'h00010, 16'h00F0, "R5 id exit");
        wr(19'h00010, 16'h00F0);

        // R7 query from read mode, R6 exit clears it
        expect_op(4'd9, 19'h00055, 16'h0098, "R7 query from read");
        wr(19'h00055, 16'h0098);
        chk_modes(0, 1, 0, "R7 cfi_mode set");
        expect_op(4'd8, 19'h00000, 16'h00F0, "R6 single exit");
        wr(19'h00000, 16'h00F0);
        chk_modes(0, 0, 0, "R6 exit clears query");

        // R6 id entry, R7 query inside id mode, R6 three-cycle exit
        unlock();
        expect_op(4'd7, 19'h00555, 16'h0090, "R6 id entry");
        wr(19'h00555, 16'h0090);
        chk_modes(1, 0, 0, "R6 id_mode set");
        expect_op(4'd9, 19'h00155, 16'h0098, "R7 query from id mode");
        wr(19'h00155, 16'h0098);
        chk_modes(1, 1, 0, "R7 both modes");
        unlock();
        expect_op(4'd8, 19'h00555, 16'h00F0, "R6 three-cycle exit");
        wr(19'h00555, 16'h00F0);
        chk_modes(0, 0, 0, "R6 modes cleared");

        // R8 protection register
        unlock(); wr(19'h00555, 16'h00C0);
        expect_op(4'd10, 19'h00081, 16'h1234, "R8 prot program");
        wr(19'h00081, 16'h1234);
        unlock(); wr(19'h00555, 16'h00C0);
        expect_op(4'd11, 19'h00080, 16'h00FD, "R8 prot lock");
        wr(19'h00080, 16'h00FD);
        unlock(); wr(19'h00555, 16'h00C0);
        expect_op(4'd10, 19'h00080, 16'h0002, "R8 D1 set is program");
        wr(19'h00080, 16'h0002);

        // R9 configuration
        unlock(); wr(19'h00555, 16'h00D0);
        expect_op(4'd12, 19'h00000, 16'h0001, "R9 cfg write");
        wr(19'h00000, 16'h0001);
        unlock(); wr(19'h00555, 16'h00D0);
        wr(19'h00000, 16'h0005);
        expect_op(4'd5, 19'h00003, 16'h00B0, "R9 bad value left idle");
        wr(19'h00003, 16'h00B0);

        // R12 broken sequences
        wr(19'h00555, 16'h00AA); wr(19'h002AA, 16'h0011);
        wr(19'h002AA, 16'h0055);
        wr(19'h00555, 16'h00AA); wr(19'h00100, 16'h00B0);
        expect_op(4'd6, 19'h00004, 16'h0030, "R12 decoder back in idle");
        wr(19'h00004, 16'h0030);

        // R11 busy cycles ignored and do not move the sequence
        prog_busy = 1'b1;
        wr(19'h00005, 16'h00B0);
        wr(19'h00555, 16'h00AA);
        prog_busy = 1'b0;
        wr(19'h002AA, 16'h0055); wr(19'h00555, 16'h00A0);
        unlock();
        prog_busy = 1'b1;
        wr(19'h00555, 16'h0077);
        prog_busy = 1'b0;
        wr(19'h00555, 16'h00A0);
        expect_op(4'd1, 19'h00900, 16'h0F0F, "R11 sequence kept across busy");
        wr(19'h00900, 16'h0F0F);

        // R1 chip enable first, address and data change during the cycle
        @(negedge clk); ce_n = 1'b0; addr = 19'h11111; data = 16'h0000;
        @(negedge clk); we_n = 1'b0; addr = 19'h00321; data = 16'h0000;
        @(negedge clk); addr = 19'h22222; data = 16'h00B0;
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        expect_op(4'd5, 19'h00321, 16'h00B0, "R1 edge latching");
        repeat (3) @(negedge clk);
        // R1 output enable low inhibits the write
        @(negedge clk); oe_n = 1'b0; addr = 19'h00006; data = 16'h00B0; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R1 pending after inhibited write", 64'(exp_q.size()), 64'd0);

        // R13 reset mid-sequence and in id mode
        unlock();
        expect_op(4'd7, 19'h00555, 16'h0090, "R13 setup id entry");
        wr(19'h00555, 16'h0090);
        wr(19'h00555, 16'h00AA);
        do_reset();
        chk_modes(0, 0, 0, "R13 reset clears id");
        wr(19'h002AA, 16'h0055); wr(19'h00555, 16'h00A0); wr(19'h00700, 16'h1111);
        chk(exp_q.size() == 0, "R13 partial sequence cleared", 64'(exp_q.size()), 64'd0);

        // R10 single-pulse program mode
        ext_prefix();
        expect_op(4'd13, 19'h00555, 16'h00A0, "R4 spm entry");
        wr(19'h00555, 16'h00A0);
        chk_modes(0, 0, 1, "R10 spm_mode set");
        expect_op(4'd1, 19'h00100, 16'h00B0, "R10 suspend code programs");
        wr(19'h00100, 16'h00B0);
        expect_op(4'd1, 19'h00555, 16'h00AA, "R10 unlock code programs");
        wr(19'h00555, 16'h00AA);
        expect_op(4'd1, 19'h00200, 16'h0030, "R10 resume code programs");
        wr(19'h00200, 16'h0030);
        chk_modes(0, 0, 1, "R10 spm sticky");
        do_reset();
        chk_modes(0, 0, 0, "R13 reset clears spm");
        expect_op(4'd5, 19'h00300, 16'h00B0, "R13 normal decode after reset");
        wr(19'h00300, 16'h00B0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R12 scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule